// File: doc/BRIEF.md
# Shutter and Veto Sequencer

This block drives a detector shutter line and a trigger-veto line through a programmed timeline. A sequence is launched by one event: either the rising edge of one chosen external trigger input, or a tick from an internal periodic generator. From that launch, three programmable counts decide when the shutter opens, when the veto is lifted, and when the shutter closes again with the veto restored. The block runs on a fast clock, but its sequencing state only advances on cycles where a one-cycle strobe input is high. Every count is therefore a number of strobe pulses.

A small synchronous register port sets the enables, the trigger source, the generator period and the three delays. It also holds a run flag. The run flag is presented on an output, and it gates the sequencer. When the run flag rises, a synchronisation pulse is issued on the next strobe. That pulse is exactly one strobe interval long.

Top module: `shutter_seq`

## Requirements
- R1: After reset the shutter is 0, the veto is 1, the sync pulse is 0, run-active is 0, and every register reads back as 0.
- R2: A write with `reg_wr` high stores `reg_wdata` into the register at `reg_addr`, and the register reads back combinationally on `reg_rdata`. Unused bits read as 0. The registers are at these addresses:
  - 0: control. Bit 0 is the sequence enable and bit 1 is the internal-generator enable.
  - 1: source select, SEL_W bits wide.
  - 2: generator period, DLY_W bits wide.
  - 3: open delay.
  - 4: unveto delay.
  - 5: close delay.
  - 6: run flag, bit 0.
  - 7: unmapped. A write to it has no effect and it reads 0.
- R3: `run_active_o` equals the run flag from the clock after the write. When the flag rises, `sync_o` goes high at the next strobe edge and goes low at the following strobe edge. A strobe taken while the flag is low clears `sync_o`.
- R4: With source select value s < N_TRIG, a sequence is launched only by a strobe cycle on which `trig_in[s]` is 1 and was 0 at the previous strobe. A held level does not launch a sequence, and other inputs do not launch one.
- R5: Counting the launch strobe as 0, the open, unveto and close edges take effect at the strobe whose count equals the open, unveto and close delay respectively. The open edge sets the shutter to 1. The unveto edge sets the veto to 0. The close edge sets the shutter to 0 and the veto to 1.
- R6: A launch event during a running sequence is ignored, and the running count continues undisturbed.
- R7: With source select at N_TRIG or above and both control bits set, the generator emits a launch event every PERIOD strobes. The first event comes on the PERIOD-th strobe after enabling. A period of 0 emits no events.
- R8: At any strobe where the sequence enable or the run flag is 0, the shutter is forced to 0, the veto to 1, and any running sequence is abandoned. Launch events at such a strobe are ignored.
- R9: If the close delay is smaller than the open or unveto delay, each edge still fires at its own count. The shutter is then forced to 0 and the veto to 1 one strobe after the larger of the open and unveto delays, and the sequence ends there.
- R10: `shutter_o`, `veto_o` and `sync_o` change only at strobe edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb | input | 1 | One-cycle strobe marking a slow-rate step |
| trig_in | input | N_TRIG | External trigger inputs |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| shutter_o | output | 1 | Shutter line |
| veto_o | output | 1 | Trigger veto, high while triggers are blocked |
| run_active_o | output | 1 | Run flag |
| sync_o | output | 1 | One-strobe synchronisation pulse on run start |

## Verification
Suppose the step counter drifts or is restarted by a stray launch. The shutter and veto edges would then move to the wrong strobe, or a close edge would be missing. This shows at the ports within one strobe of the programmed count, so the bench checks both lines after every strobe of each timeline. A generator counter that goes wrong shifts the first shutter opening away from strobe PERIOD+T1. A bad edge-detect register shows up as a launch from a held level within one strobe.

// File: rtl/shutter_seq_pkg.sv
package shutter_seq_pkg;

    localparam int unsigned ADDR_W = 3;

    // register addresses; the order is decoded by the register port
    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SRC      = 3'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD   = 3'd2;
    localparam logic [ADDR_W-1:0] A_T_OPEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_T_UNVETO = 3'd4;
    localparam logic [ADDR_W-1:0] A_T_CLOSE  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RUN      = 3'd6;

    typedef struct packed {
        logic int_en;   // bit 1
        logic seq_en;   // bit 0
    } ctrl_t;

endpackage

// File: rtl/seq_regs.sv
module seq_regs
    import shutter_seq_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned SEL_W = 3,
    parameter int unsigned DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output ctrl_t             ctrl_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DLY_W-1:0]  period_o,
    output logic [DLY_W-1:0]  t_open_o,
    output logic [DLY_W-1:0]  t_unveto_o,
    output logic [DLY_W-1:0]  t_close_o,
    output logic              run_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [SEL_W-1:0]  sel;
        logic [DLY_W-1:0]  period;
        logic [DLY_W-1:0]  t_open;
        logic [DLY_W-1:0]  t_unveto;
        logic [DLY_W-1:0]  t_close;
        logic              run;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                A_CTRL:     regs_d.ctrl     = ctrl_t'(wdata[1:0]);
                A_SRC:      regs_d.sel      = wdata[SEL_W-1:0];
                A_PERIOD:   regs_d.period   = wdata[DLY_W-1:0];
                A_T_OPEN:   regs_d.t_open   = wdata[DLY_W-1:0];
                A_T_UNVETO: regs_d.t_unveto = wdata[DLY_W-1:0];
                A_T_CLOSE:  regs_d.t_close  = wdata[DLY_W-1:0];
                A_RUN:      regs_d.run      = wdata[0];
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:     rdata[1:0]       = regs_q.ctrl;
            A_SRC:      rdata[SEL_W-1:0] = regs_q.sel;
            A_PERIOD:   rdata[DLY_W-1:0] = regs_q.period;
            A_T_OPEN:   rdata[DLY_W-1:0] = regs_q.t_open;
            A_T_UNVETO: rdata[DLY_W-1:0] = regs_q.t_unveto;
            A_T_CLOSE:  rdata[DLY_W-1:0] = regs_q.t_close;
            A_RUN:      rdata[0]         = regs_q.run;
            default:    rdata = '0;
        endcase
    end

    assign ctrl_o     = regs_q.ctrl;
    assign sel_o      = regs_q.sel;
    assign period_o   = regs_q.period;
    assign t_open_o   = regs_q.t_open;
    assign t_unveto_o = regs_q.t_unveto;
    assign t_close_o  = regs_q.t_close;
    assign run_o      = regs_q.run;

    // R2
    run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RUN) |=> (run_o == $past(wdata[0])));

endmodule

// File: rtl/seq_sync.sv
module seq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic run_i,
    output logic sync_o
);

    typedef struct packed {
        logic seen;   // run flag as sampled on the last strobe
        logic pulse;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.seen  = run_i;
            st_d.pulse = run_i && !st_q.seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pulse;

    // R3
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !run_i) |=> !sync_o);

    // R10
    sync_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(sync_o));

endmodule

// File: rtl/seq_source.sv
module seq_source #(
    parameter int unsigned N_TRIG = 4,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [N_TRIG-1:0] trig_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              gen_on_i,
    input  logic [DLY_W-1:0]  period_i,
    output logic              event_o
);

    typedef struct packed {
        logic [N_TRIG-1:0] prev;   // trigger levels at the last strobe
        logic [DLY_W-1:0]  gcnt;   // generator strobe counter
    } src_t;

    src_t st_d, st_q;

    logic [N_TRIG-1:0] hit;
    logic              ext_hit;
    logic              int_mode;
    logic              tick;

    for (genvar i = 0; i < N_TRIG; i++) begin : g_edge
        assign hit[i] = stb && trig_i[i] && !st_q.prev[i] && (sel_i == SEL_W'(i));
    end

    assign ext_hit  = |hit;
    assign int_mode = (sel_i >= SEL_W'(N_TRIG));
    assign tick     = stb && gen_on_i && (period_i != '0) &&
                      (st_q.gcnt >= period_i - DLY_W'(1));

    always_comb begin
        st_d = st_q;
        if (stb) st_d.prev = trig_i;
        if (!gen_on_i || period_i == '0) begin
            st_d.gcnt = '0;
        end else if (stb) begin
            st_d.gcnt = tick ? '0 : st_q.gcnt + DLY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_o = int_mode ? tick : ext_hit;

    // R7
    gen_every_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && gen_on_i && int_mode && period_i == DLY_W'(1)) |-> event_o);

    // R4
    held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !int_mode && (trig_i == $past(trig_i)) && $past(stb)) |-> !event_o);

endmodule

// File: rtl/seq_timeline.sv
module seq_timeline #(
    parameter int unsigned DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             en_i,
    input  logic             event_i,
    input  logic [DLY_W-1:0] t_open_i,
    input  logic [DLY_W-1:0] t_unveto_i,
    input  logic [DLY_W-1:0] t_close_i,
    output logic             shutter_o,
    output logic             veto_o
);

    localparam int unsigned CW = DLY_W + 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          shutter;
        logic          veto;
    } tl_t;

    localparam tl_t IDLE = '{busy: 1'b0, cnt: '0, shutter: 1'b0, veto: 1'b1};

    tl_t st_d, st_q;

    logic [DLY_W-1:0] t_hi;
    logic [CW-1:0]    end_cnt;
    logic [CW-1:0]    step;
    logic             active;

    assign t_hi    = (t_open_i > t_unveto_i) ? t_open_i : t_unveto_i;
    assign end_cnt = (t_close_i >= t_hi) ? {1'b0, t_close_i}
                                         : {1'b0, t_hi} + CW'(1);

    always_comb begin
        st_d   = st_q;
        active = 1'b0;
        step   = '0;
        if (st_q.busy) begin
            active = 1'b1;
            step   = st_q.cnt + CW'(1);
        end else if (event_i) begin
            active = 1'b1;
        end
        if (stb) begin
            if (!en_i) begin
                st_d = IDLE;
            end else if (active) begin
                st_d.busy = 1'b1;
                st_d.cnt  = step;
                if (step == {1'b0, t_open_i})   st_d.shutter = 1'b1;
                if (step == {1'b0, t_unveto_i}) st_d.veto    = 1'b0;
                if (step == {1'b0, t_close_i}) begin
                    st_d.shutter = 1'b0;
                    st_d.veto    = 1'b1;
                end
                if (step == end_cnt) st_d = IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE;
        else        st_q <= st_d;
    end

    assign shutter_o = st_q.shutter;
    assign veto_o    = st_q.veto;

    // R10
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(shutter_o) && $stable(veto_o)));

    // R8
    gate_forces_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !en_i) |=> (!shutter_o && veto_o));

    // R5
    open_inside_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutter_o) |-> st_q.busy);

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && stb && en_i && event_i) |=> (!st_q.busy || st_q.cnt != '0));

endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutter_seq_pkg::*;
#(
    parameter int unsigned N_TRIG = 4,
    parameter int unsigned DW     = 32,
    parameter int unsigned DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              shutter_o,
    output logic              veto_o,
    output logic              run_active_o,
    output logic              sync_o
);

    localparam int unsigned SEL_W = $clog2(N_TRIG + 1);

    ctrl_t            ctrl;
    logic [SEL_W-1:0] sel;
    logic [DLY_W-1:0] period, t_open, t_unveto, t_close;
    logic             run;
    logic             seq_en;
    logic             gen_on;
    logic             launch;

    seq_regs #(.DW(DW), .SEL_W(SEL_W), .DLY_W(DLY_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .ctrl_o     (ctrl),
        .sel_o      (sel),
        .period_o   (period),
        .t_open_o   (t_open),
        .t_unveto_o (t_unveto),
        .t_close_o  (t_close),
        .run_o      (run)
    );

    assign seq_en = ctrl.seq_en && run;
    assign gen_on = seq_en && ctrl.int_en;

    seq_source #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .DLY_W(DLY_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb),
        .trig_i   (trig_in),
        .sel_i    (sel),
        .gen_on_i (gen_on),
        .period_i (period),
        .event_o  (launch)
    );

    seq_timeline #(.DLY_W(DLY_W)) u_tl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (stb),
        .en_i       (seq_en),
        .event_i    (launch),
        .t_open_i   (t_open),
        .t_unveto_i (t_unveto),
        .t_close_i  (t_close),
        .shutter_o  (shutter_o),
        .veto_o     (veto_o)
    );

    seq_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .run_i  (run),
        .sync_o (sync_o)
    );

    assign run_active_o = run;

    // R1
    veto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active_o && $past(!run_active_o) && $past(stb)) |-> (veto_o && !shutter_o));

endmodule

// File: tb/sim_shutter_seq.sv
module sim_shutter_seq;

    localparam int N_TRIG = 4;
    localparam int DW     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stb = 1'b0;
    logic [N_TRIG-1:0] trig_in = '0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic              shutter_o, veto_o, run_active_o, sync_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    shutter_seq #(.N_TRIG(N_TRIG), .DW(DW), .DLY_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .stb(stb), .trig_in(trig_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .shutter_o(shutter_o), .veto_o(veto_o),
        .run_active_o(run_active_o), .sync_o(sync_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // one strobe edge, then two quiet cycles; sampling after return
    task automatic tick();
        @(negedge clk); stb = 1'b1;
        @(negedge clk); stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic step(input string req, input logic sh, input logic vt);
        tick();
        chk({req, " shutter"}, shutter_o, sh);
        chk({req, " veto"}, veto_o, vt);
    endtask

    task automatic set_delays(input int t1, input int t2, input int t3);
        wr(3'd3, t1); wr(3'd4, t2); wr(3'd5, t3);
    endtask

    task automatic test_reset();
        logic [DW-1:0] d;
        chk("R1 shutter", shutter_o, 0);
        chk("R1 veto", veto_o, 1);
        chk("R1 sync", sync_o, 0);
        chk("R1 run", run_active_o, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 readback", d, 0);
        end
    endtask

    task automatic test_regs();
        logic [DW-1:0] d;
        wr(3'd3, 32'h1234_0005); rd(3'd3, d); chk("R2 open mask", d, 32'h5);
        wr(3'd0, 32'hFF);        rd(3'd0, d); chk("R2 ctrl mask", d, 32'h3);
        wr(3'd1, 32'hFF);        rd(3'd1, d); chk("R2 sel mask", d, 32'h7);
        wr(3'd2, 32'h0001_0009); rd(3'd2, d); chk("R2 period", d, 32'h9);
        wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, d); chk("R2 unmapped", d, 0);
        rd(3'd6, d); chk("R2 run untouched", d, 0);
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0);
    endtask

    task automatic test_run_sync();
        wr(3'd6, 1);
        chk("R3 run active", run_active_o, 1);
        chk("R3 no sync before strobe", sync_o, 0);
        tick(); chk("R3 sync high", sync_o, 1);
        tick(); chk("R3 sync one strobe", sync_o, 0);
        tick(); chk("R3 sync stays low", sync_o, 0);
    endtask

    task automatic test_seq();
        wr(3'd1, 0); set_delays(2, 3, 5); wr(3'd0, 1);
        tick();
        trig_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 shutter between strobes", shutter_o, 0);
        step("R5 c0", 0, 1); step("R5 c1", 0, 1); step("R5 c2", 1, 1);
        step("R5 c3", 1, 0); step("R5 c4", 1, 0); step("R5 c5", 0, 1);
        for (int k = 0; k < 6; k++) step("R4 held level", 0, 1);
        trig_in[1] = 1'b1;
        for (int k = 0; k < 3; k++) step("R4 unselected", 0, 1);
        trig_in = '0;
        tick();
    endtask

    task automatic test_busy();
        trig_in[0] = 1'b1;
        step("R6 c0", 0, 1); step("R6 c1", 0, 1);
        trig_in[0] = 1'b0;
        step("R6 c2", 1, 1);
        trig_in[0] = 1'b1;
        step("R6 c3 retrigger ignored", 1, 0);
        step("R6 c4", 1, 0);
        step("R6 c5 closes on time", 0, 1);
        trig_in[0] = 1'b0;
        tick();
    endtask

    task automatic test_order();
        set_delays(1, 4, 2);
        trig_in[0] = 1'b1;
        step("R9 c0", 0, 1); step("R9 c1", 1, 1); step("R9 c2", 0, 1);
        step("R9 c3", 0, 1); step("R9 c4", 0, 0); step("R9 c5 restore", 0, 1);
        trig_in[0] = 1'b0;
        tick();
    endtask

    task automatic test_gate();
        set_delays(1, 2, 6);
        trig_in[0] = 1'b1;
        step("R8 c0", 0, 1); step("R8 c1", 1, 1); step("R8 c2", 1, 0);
        wr(3'd6, 0);
        chk("R8 run low", run_active_o, 0);
        step("R8 forced idle", 0, 1);
        trig_in[0] = 1'b0; tick();
        trig_in[0] = 1'b1;
        for (int k = 0; k < 3; k++) step("R8 run low ignores", 0, 1);
        trig_in[0] = 1'b0;
        wr(3'd6, 1);
        tick(); chk("R3 sync on restart", sync_o, 1);
        wr(3'd0, 0);
        trig_in[0] = 1'b1;
        for (int k = 0; k < 3; k++) step("R8 enable low ignores", 0, 1);
        trig_in[0] = 1'b0;
        tick();
    endtask

    task automatic test_internal();
        set_delays(1, 1, 2);
        wr(3'd2, 6); wr(3'd1, N_TRIG); wr(3'd0, 3);
        for (int k = 1; k <= 14; k++) begin
            bit open = (k == 7) || (k == 13);
            step($sformatf("R7 strobe %0d", k), open, !open);
        end
        wr(3'd2, 0);
        for (int k = 0; k < 8; k++) step("R7 period zero", 0, 1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regs();
        test_run_sync();
        test_seq();
        test_busy();
        test_order();
        test_gate();
        wr(3'd0, 1);
        test_internal();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule